// File: doc/BRIEF.md
# I2C Two-Stage Clock Tick Generator

This block derives the timing enables for an I2C bus engine from the peripheral clock. It does not produce a derived clock. A power-of-two prescaler produces a one-cycle sampling tick every 2^E clock cycles. E is the 4-bit exponent field of an 11-bit clock control word. A second counter groups these sampling ticks into SCL bit periods. Each bit period holds 10×(K+1) sampling ticks, where K is the 7-bit multiplier field of the same word.

A level output tells the bus engine whether SCL should currently be driven low or released high. Two strobes mark the tick that ends the low half and the tick that ends the whole bit period. Writing the clock control word restarts both counters. A hold input freezes both counters so that an engine can stretch the clock.

Top module: `i2c_tick_gen`

## Requirements
- R1: After reset the control word is zero (E=0, K=0). `samp_tick` is then high on every cycle without hold, `scl_high` starts at 0, and a bit period lasts 10 clock cycles.
- R2: `samp_tick` is a one-cycle pulse that rises on every 2^E-th cycle in which `hold` is low, counting from the last restart. E is `cfg_wdata[3:0]`, and E=15 gives one tick per 32768 unheld cycles.
- R3: `bit_tick` pulses together with every 10×(K+1)-th sampling tick after a restart, where K is `cfg_wdata[10:4]`. It is never high without `samp_tick`.
- R4: `scl_high` is 0 during the first 5×(K+1) sampling intervals of each bit period and 1 during the remaining 5×(K+1).
- R5: A cycle with `cfg_wr` high loads `cfg_wdata` into the control word and restarts both counters. The next cycle is position zero of a new sampling interval and of a new low half, and it uses the new E and K.
- R6: While `hold` is high, `samp_tick`, `scl_rise` and `bit_tick` stay low, and `scl_high` and both counters keep their values. Counting resumes from the frozen position once `hold` falls.
- R7: When `cfg_wr` and `hold` are high in the same cycle, the write takes effect and the counters restart. Hold keeps freezing the restarted counters in later cycles.
- R8: `scl_rise` pulses together with the sampling tick that ends the low half, which is the 5×(K+1)-th tick of the period. `scl_high` is 1 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Write strobe for the clock control word |
| cfg_wdata | input | 11 | Control word: [3:0] exponent E, [10:4] multiplier K |
| hold | input | 1 | Freezes both counters while high |
| samp_tick | output | 1 | Sampling enable, one cycle wide |
| scl_high | output | 1 | SCL phase: 0 = drive low, 1 = release high |
| scl_rise | output | 1 | Strobe on the tick that ends the low half |
| bit_tick | output | 1 | Strobe on the tick that ends the bit period |

## Verification
Two actions can fall in the same cycle and compete for the counters: a control-word write, and either hold or a tick that would advance or wrap a counter. The bench provokes this in two ways. Random segments issue writes at arbitrary positions while hold is randomly asserted, and directed cases place a write exactly on a `bit_tick` cycle and inside a held stretch. Each outcome is judged against a bench model that counts only unheld cycles since the last write. That model derives every output from that count with division and modulo, so a restart that loses to hold or to a wrap shows up as a shifted tick position.

// File: rtl/i2c_tick_pkg.sv
package i2c_tick_pkg;

  localparam int DEF_EXP_W = 4;
  localparam int DEF_MUL_W = 7;
  localparam int DEF_SEG   = 5;

  // Last value of the prescale counter for exponent e
  function automatic int samp_limit(input int e);
    return (1 << e) - 1;
  endfunction

  // Number of sampling ticks in one SCL bit period
  function automatic int period_len(input int mul, input int seg);
    return 2 * seg * (mul + 1);
  endfunction

  // Number of sampling ticks in the low half of one bit period
  function automatic int half_len(input int mul, input int seg);
    return seg * (mul + 1);
  endfunction

endpackage

// File: rtl/i2c_tick_cfg_reg.sv
module i2c_tick_cfg_reg #(
  parameter int CFG_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [CFG_W-1:0] wdata_i,
  output logic [CFG_W-1:0] cfg_o,
  output logic             restart_o
);

  logic [CFG_W-1:0] cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (wr_i) begin
      cfg_q <= wdata_i;
    end
  end

  assign cfg_o     = cfg_q;
  // counters clear on the same edge that loads the new word
  assign restart_o = wr_i;

endmodule

// File: rtl/i2c_tick_prescaler.sv
module i2c_tick_prescaler #(
  parameter int EXP_W = 4,
  parameter int PRE_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart_i,
  input  logic             hold_i,
  input  logic [EXP_W-1:0] exp_i,
  output logic             tick_o,
  output logic             wrap_o
);

  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] limit;

  assign limit  = PRE_W'(i2c_tick_pkg::samp_limit(int'(exp_i)));
  assign wrap_o = (cnt_q == limit);
  assign tick_o = wrap_o && !hold_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart_i) begin
      cnt_q <= '0;
    end else if (!hold_i) begin
      cnt_q <= wrap_o ? '0 : cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/i2c_tick_period.sv
module i2c_tick_period #(
  parameter int MUL_W = 7,
  parameter int SEG   = 5,
  parameter int PER_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart_i,
  input  logic             samp_tick_i,
  input  logic [MUL_W-1:0] mul_i,
  output logic             scl_high_o,
  output logic             rise_o,
  output logic             last_o
);

  logic [PER_W-1:0] cnt_q;
  logic [PER_W-1:0] len;
  logic [PER_W-1:0] half;
  logic             at_last;
  logic             at_half;

  assign len     = PER_W'(i2c_tick_pkg::period_len(int'(mul_i), SEG));
  assign half    = PER_W'(i2c_tick_pkg::half_len(int'(mul_i), SEG));
  assign at_last = (cnt_q == len - 1'b1);
  assign at_half = (cnt_q == half - 1'b1);

  assign scl_high_o = (cnt_q >= half);
  assign rise_o     = samp_tick_i && at_half;
  assign last_o     = samp_tick_i && at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart_i) begin
      cnt_q <= '0;
    end else if (samp_tick_i) begin
      cnt_q <= at_last ? '0 : cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/i2c_tick_gen.sv
module i2c_tick_gen #(
  parameter int EXP_W = i2c_tick_pkg::DEF_EXP_W,
  parameter int MUL_W = i2c_tick_pkg::DEF_MUL_W,
  parameter int SEG   = i2c_tick_pkg::DEF_SEG
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_wr,
  input  logic [EXP_W+MUL_W-1:0] cfg_wdata,
  input  logic                   hold,
  output logic                   samp_tick,
  output logic                   scl_high,
  output logic                   scl_rise,
  output logic                   bit_tick
);

  localparam int CFG_W = EXP_W + MUL_W;
  localparam int PRE_W = (1 << EXP_W) - 1;
  localparam int PER_W = $clog2(2 * SEG * (1 << MUL_W));

  // named internal events, observed by the bound checker
  logic [CFG_W-1:0] cfg_q;
  logic [EXP_W-1:0] cfg_exp;
  logic [MUL_W-1:0] cfg_mul;
  logic             restart;
  logic             pre_wrap;

  i2c_tick_cfg_reg #(.CFG_W(CFG_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_i      (cfg_wr),
    .wdata_i   (cfg_wdata),
    .cfg_o     (cfg_q),
    .restart_o (restart)
  );

  assign cfg_exp = cfg_q[EXP_W-1:0];
  assign cfg_mul = cfg_q[CFG_W-1:EXP_W];

  i2c_tick_prescaler #(.EXP_W(EXP_W), .PRE_W(PRE_W)) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (restart),
    .hold_i    (hold),
    .exp_i     (cfg_exp),
    .tick_o    (samp_tick),
    .wrap_o    (pre_wrap)
  );

  i2c_tick_period #(.MUL_W(MUL_W), .SEG(SEG), .PER_W(PER_W)) u_per (
    .clk         (clk),
    .rst_n       (rst_n),
    .restart_i   (restart),
    .samp_tick_i (samp_tick),
    .mul_i       (cfg_mul),
    .scl_high_o  (scl_high),
    .rise_o      (scl_rise),
    .last_o      (bit_tick)
  );

endmodule

// File: rtl/i2c_tick_gen_chk.sv
module i2c_tick_gen_chk #(
  parameter int EXP_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_wr,
  input logic             hold,
  input logic             samp_tick,
  input logic             scl_high,
  input logic             scl_rise,
  input logic             bit_tick,
  input logic             pre_wrap,
  input logic [EXP_W-1:0] cfg_exp
);

  AST_FAST_EVERY_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_exp == '0 && !hold) |-> samp_tick); // R2

  AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> (!samp_tick && !scl_rise && !bit_tick)); // R6

  AST_HOLD_PHASE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !cfg_wr) |=> $stable(scl_high)); // R6

  AST_HOLD_PRESCALE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !cfg_wr) |=> $stable(pre_wrap)); // R6

  AST_BIT_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> (samp_tick && scl_high)); // R3

  AST_BIT_THEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && !cfg_wr) |=> !scl_high); // R3

  AST_RISE_FROM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    scl_rise |-> (samp_tick && !scl_high)); // R8

  AST_RISE_THEN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_rise && !cfg_wr) |=> scl_high); // R4

  AST_WRITE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> !scl_high); // R5

  AST_WRITE_UNDER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && hold) |=> !scl_high); // R7

endmodule

bind i2c_tick_gen i2c_tick_gen_chk #(.EXP_W(EXP_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_wr    (cfg_wr),
  .hold      (hold),
  .samp_tick (samp_tick),
  .scl_high  (scl_high),
  .scl_rise  (scl_rise),
  .bit_tick  (bit_tick),
  .pre_wrap  (pre_wrap),
  .cfg_exp   (cfg_exp)
);

// File: tb/i2c_tick_gen_bench.sv
module i2c_tick_gen_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [10:0] cfg_wdata = '0;
  logic        hold = 1'b0;
  logic        samp_tick;
  logic        scl_high;
  logic        scl_rise;
  logic        bit_tick;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model: unheld cycles since the last restart, plus the active fields
  longint n_cyc = 0;
  int     m_e = 0;
  int     m_k = 0;

  always #5 clk = ~clk;

  i2c_tick_gen u_i2c_tick_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_wdata (cfg_wdata),
    .hold      (hold),
    .samp_tick (samp_tick),
    .scl_high  (scl_high),
    .scl_rise  (scl_rise),
    .bit_tick  (bit_tick)
  );

  function automatic bit exp_samp(longint n, int e, bit h);
    return !h && (((n + 1) % (64'd1 << e)) == 0);
  endfunction

  function automatic longint ticks_done(longint n, int e);
    return n / (64'd1 << e);
  endfunction

  function automatic bit exp_high(longint n, int e, int k);
    return (ticks_done(n, e) % (10 * (k + 1))) >= (5 * (k + 1));
  endfunction

  function automatic bit exp_bit(longint n, int e, int k, bit h);
    return exp_samp(n, e, h) && (((ticks_done(n, e) + 1) % (10 * (k + 1))) == 0);
  endfunction

  function automatic bit exp_rise(longint n, int e, int k, bit h);
    return exp_samp(n, e, h) &&
           (((ticks_done(n, e) + 1) % (10 * (k + 1))) == (5 * (k + 1)));
  endfunction

  task automatic cmp(input logic act, input logic expv, input string tag);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %b expected %b (E=%0d K=%0d n=%0d t=%0t)",
               tag, act, expv, m_e, m_k, n_cyc, $time);
    end
  endtask

  // one cycle: drive at negedge, compare 1 ns before the next posedge
  task automatic step(input bit wr, input logic [10:0] wd, input bit h, input string ctx);
    @(negedge clk);
    cfg_wr = wr;
    cfg_wdata = wd;
    hold = h;
    #4;
    cmp(samp_tick, exp_samp(n_cyc, m_e, h),        {"R2 samp_tick ", ctx});
    cmp(scl_high,  exp_high(n_cyc, m_e, m_k),      {"R4 scl_high ", ctx});
    cmp(bit_tick,  exp_bit(n_cyc, m_e, m_k, h),    {"R3 bit_tick ", ctx});
    cmp(scl_rise,  exp_rise(n_cyc, m_e, m_k, h),   {"R8 scl_rise ", ctx});
    @(posedge clk);
    if (wr) begin
      m_e = int'(wd[3:0]);
      m_k = int'(wd[10:4]);
      n_cyc = 0;
    end else if (!h) begin
      n_cyc++;
    end
  endtask

  task automatic run(input int cycles, input int hold_pct, input string ctx);
    for (int i = 0; i < cycles; i++) begin
      step(1'b0, 11'd0, (($urandom % 100) < hold_pct), ctx);
    end
  endtask

  function automatic logic [10:0] word(int e, int k);
    return {7'(k), 4'(e)};
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #4;
    // R1: reset state before the first counting edge
    cmp(scl_high, 1'b0, "R1 scl_high after reset");
    cmp(samp_tick, 1'b1, "R1 samp_tick after reset");
    @(posedge clk);
    n_cyc = 1;
    // R1: default period of 10 cycles with no hold
    run(40, 0, "R1 default");
    // R2/R3/R4/R8: a few fixed settings
    step(1'b1, word(2, 1), 1'b0, "R5 write");
    run(200, 0, "R2 E=2 K=1");
    step(1'b1, word(0, 127), 1'b0, "R5 write");
    run(2600, 0, "R3 K=127");
    // R5: write exactly on a bit_tick cycle (E=0 K=0: 10th unheld cycle)
    step(1'b1, word(0, 0), 1'b0, "R5 write");
    run(9, 0, "R5 pre");
    step(1'b1, word(1, 2), 1'b0, "R5 write on bit_tick");
    run(150, 0, "R5 after");
    // R6: long hold mid-period
    run(13, 0, "R6 pre");
    for (int i = 0; i < 20; i++) step(1'b0, 11'd0, 1'b1, "R6 held");
    run(100, 0, "R6 resumed");
    // R7: write while hold is high, hold continues afterwards
    step(1'b1, word(1, 0), 1'b1, "R7 write under hold");
    for (int i = 0; i < 5; i++) step(1'b0, 11'd0, 1'b1, "R7 still held");
    run(60, 0, "R7 resumed");
    // random segments mixing writes and hold
    for (int s = 0; s < 200; s++) begin
      step(1'b1, word(int'($urandom % 4), int'($urandom % 4)),
           (($urandom % 4) == 0), "R7 random write");
      run(50 + int'($urandom % 350), 12, "R6 random");
    end
    // R2: largest exponent, two ticks
    step(1'b1, word(15, 0), 1'b0, "R5 write");
    run(66000, 0, "R2 E=15");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1900000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule